// File: doc/BRIEF.md
# Multiplexed Heater Array Scanner

This block drives the enable lines of a large array of ring heaters from a narrow serial control port. The heaters are arranged in groups, 16 groups of 28 heaters by default, which gives 448 enables. Ring-pattern bits arrive one at a time on a single data line and are clocked into a serial-to-parallel register by a shift strobe. A separate transfer strobe then moves the assembled word into one of two selection targets. The sel_group control input picks the target: either the ring pattern or the group token.

A single one-hot token marks the active group. A heater is switched on only when its group holds the token and its own bit in the transferred pattern is set. This lets one data line serve every heater in the array. Each ring-pattern transfer releases the pattern to the current group and then moves the token to the next group. When the token leaves the last group, it wraps back to group 0 and a one-cycle scan-done pulse is raised. A group transfer places the token directly on a chosen group. The setup_n input holds the outputs off and the token at group 0 while it is low. Both strobes are synchronous enables sampled on the block clock.

Top module: `heater_scan_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), heat_en is all zero, scan_done is 0, and the token rests on group 0.
- R2: In a cycle with shift_en high, the serial register takes ser_data into bit 0 and moves every other bit up by one place. After 28 shifts, the first bit shifted in sits at ring position 27. The register holds its value when shift_en is low, and shifting works whatever the level of setup_n.
- R3: A ring transfer (xfer_strobe high, sel_group 0, setup_n high) sets heat_en[g*28+r] to serial bit r for the group g holding the token, and sets every other group's bits to zero. The result is visible from the following cycle.
- R4: After each ring transfer the token moves to the next group. From group 15 it wraps to group 0.
- R5: scan_done is high for exactly one cycle: the cycle after a ring transfer made while the token was on group 15. It is low at all other times.
- R6: A group transfer (xfer_strobe high, sel_group 1, setup_n high) moves the token to the group numbered by serial bits [4:0] and leaves heat_en unchanged. If that number is 16 or more, the token does not move.
- R7: heat_en keeps its value in every cycle that has no ring transfer and setup_n high, including while bits are being shifted.
- R8: While setup_n is low, heat_en is cleared, scan_done is held low, the token returns to group 0, and both kinds of transfer are ignored.
- R9: When shift_en and a transfer strobe are high in the same cycle, the transfer uses the register contents from before that cycle's shift.
- R10: At most one group has any heater enabled at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial pattern bit |
| shift_en | input | 1 | Shift strobe for the serial register |
| xfer_strobe | input | 1 | Transfer strobe for the register contents |
| sel_group | input | 1 | Transfer target: 0 = ring pattern, 1 = group token |
| setup_n | input | 1 | Low = setup phase, outputs off |
| heat_en | output | 448 | Heater enables, bit g*28+r |
| scan_done | output | 1 | One-cycle pulse when the token wraps |

## Verification
The shift strobe and the transfer strobe can be active in the same cycle. In that case the transfer must use the word from before the shift, not the word after it. The bench provokes this by filling the register with ones and then raising both strobes together with a zero on the data line. It checks that the released row is all ones. A second transfer must then show the shifted word, with a zero in bit 0. The token wrap and the scan-done pulse can also fall in the same cycle as a row release, and that case is judged on every pass through group 15.

// File: rtl/heater_scan_pkg.sv
// Package: shared defaults and the transfer target encoding for the heater
// scanner. Assumes nothing beyond a single clock domain.
package heater_scan_pkg;
    localparam int DEF_GROUPS = 16;
    localparam int DEF_RINGS  = 28;

    typedef enum logic {
        XFER_RING  = 1'b0,
        XFER_GROUP = 1'b1
    } xfer_target_e;
endpackage

// File: rtl/heater_sipo.sv
// Module: serial-to-parallel register fed one bit per shift strobe.
// Assumes shift_en is a synchronous enable in the clk domain.
module heater_sipo #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             ser_data,
    output logic [WIDTH-1:0] word_q
);
    // Shift the new bit into bit 0, older bits move up one place.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (shift_en)
            word_q <= {word_q[WIDTH-2:0], ser_data};
    end

    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word_q[0] == $past(ser_data)) &&
                     (word_q[WIDTH-1:1] == $past(word_q[WIDTH-2:0])));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word_q));
endmodule

// File: rtl/heater_token.sv
// Module: one-hot group token with sequential advance, direct placement and
// a wrap pulse. Assumes adv and place are never high together (decoded by top).
module heater_token #(
    parameter int GROUPS = 16,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              adv,
    input  logic              place,
    input  logic [IDX_W-1:0]  place_idx,
    output logic [GROUPS-1:0] token_q,
    output logic              wrap_pulse
);
    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(GROUPS);
    localparam logic [GROUPS-1:0] TOKEN_HOME = GROUPS'(1);

    logic [GROUPS-1:0] placed;
    logic              idx_ok;

    // Decode the requested group number into a one-hot word.
    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_dec
            assign placed[g] = (place_idx == IDX_W'(g));
        end
    endgenerate

    // Range check for placement requests.
    assign idx_ok = (place_idx < IDX_LIMIT);

    // Token register: home on reset/clear, rotate on advance, jump on place.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            token_q <= TOKEN_HOME;
        else if (adv)
            token_q <= {token_q[GROUPS-2:0], token_q[GROUPS-1]};
        else if (place && idx_ok)
            token_q <= placed;
    end

    // Wrap pulse: registered one cycle after an advance out of the last group.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            wrap_pulse <= 1'b0;
        else
            wrap_pulse <= adv && token_q[GROUPS-1];
    end

    a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(token_q));
    a_r4_wrap_home: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clear && token_q[GROUPS-1]) |=> token_q[0]);
    a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> $past(adv && token_q[GROUPS-1]));
    a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |=> !wrap_pulse);
    a_r6_bad_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (place && !adv && !clear && !idx_ok) |=> $stable(token_q));
endmodule

// File: rtl/heater_matrix.sv
// Module: AND of group token and ring pattern, registered into the heater
// enable word. Assumes ring_wr is already qualified by the setup phase.
module heater_matrix #(
    parameter int GROUPS = 16,
    parameter int RINGS  = 28
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     ring_wr,
    input  logic [GROUPS-1:0]        token,
    input  logic [RINGS-1:0]         pattern,
    output logic [GROUPS*RINGS-1:0]  heat_q
);
    localparam int HEATERS = GROUPS * RINGS;

    logic [HEATERS-1:0] heat_next;
    logic [GROUPS-1:0]  grp_any;

    // One gated row per group: token bit masks the shared pattern.
    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_row
            assign heat_next[g*RINGS +: RINGS] = {RINGS{token[g]}} & pattern;
            assign grp_any[g] = |heat_q[g*RINGS +: RINGS];
        end
    endgenerate

    // Output latch: cleared in setup, loaded only on a ring transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            heat_q <= '0;
        else if (ring_wr)
            heat_q <= heat_next;
    end

    a_r10_one_group: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_any));
    a_r8_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (heat_q == '0));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !ring_wr) |=> $stable(heat_q));
endmodule

// File: rtl/heater_scan_top.sv
// Module: top of the heater array scanner. Decodes the two strobes and the
// target select into ring and group transfers and wires the serial register,
// token and output matrix. Assumes RINGS is at least the group index width.
module heater_scan_top
    import heater_scan_pkg::*;
#(
    parameter int GROUPS = DEF_GROUPS,
    parameter int RINGS  = DEF_RINGS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_data,
    input  logic                    shift_en,
    input  logic                    xfer_strobe,
    input  logic                    sel_group,
    input  logic                    setup_n,
    output logic [GROUPS*RINGS-1:0] heat_en,
    output logic                    scan_done
);
    localparam int IDX_W = $clog2(GROUPS) + 1;

    logic [RINGS-1:0]  word_q;
    logic [GROUPS-1:0] token_q;
    logic              xfer_ok;
    logic              ring_wr;
    logic              grp_wr;
    logic              in_setup;
    xfer_target_e      target;

    // Strobe decode: transfers only count outside the setup phase.
    assign target   = xfer_target_e'(sel_group);
    assign in_setup = !setup_n;
    assign xfer_ok  = xfer_strobe && setup_n;
    assign ring_wr  = xfer_ok && (target == XFER_RING);
    assign grp_wr   = xfer_ok && (target == XFER_GROUP);

    heater_sipo #(.WIDTH(RINGS)) u_sipo (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .ser_data (ser_data),
        .word_q   (word_q)
    );

    heater_token #(.GROUPS(GROUPS), .IDX_W(IDX_W)) u_token (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (in_setup),
        .adv        (ring_wr),
        .place      (grp_wr),
        .place_idx  (word_q[IDX_W-1:0]),
        .token_q    (token_q),
        .wrap_pulse (scan_done)
    );

    heater_matrix #(.GROUPS(GROUPS), .RINGS(RINGS)) u_matrix (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (in_setup),
        .ring_wr (ring_wr),
        .token   (token_q),
        .pattern (word_q),
        .heat_q  (heat_en)
    );

    a_r8_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !setup_n |=> !scan_done);
    a_r6_group_keeps_heat: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_wr) |=> $stable(heat_en));
endmodule

// File: tb/tb_heater_scan_top.sv
// Bench: full scans, placement, simultaneous strobes and setup phase, with a
// behavioural model built from the requirements.
module tb_heater_scan_top;
    localparam int G = 16;
    localparam int R = 28;
    localparam int H = G * R;

    logic clk = 1'b0;
    logic rst_n, ser_data, shift_en, xfer_strobe, sel_group, setup_n;
    logic [H-1:0] heat_en;
    logic         scan_done;

    int n_cmp = 0;
    int n_bad = 0;

    logic [R-1:0] m_sr;
    int           m_tok;
    logic [H-1:0] m_heat;
    logic         m_done;

    always #2ns clk = ~clk;

    heater_scan_top dut (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .shift_en(shift_en),
        .xfer_strobe(xfer_strobe), .sel_group(sel_group), .setup_n(setup_n),
        .heat_en(heat_en), .scan_done(scan_done)
    );

    function automatic logic [R-1:0] pat(int g);
        return R'((g + 1) * 32'h0123_4567 ^ 32'h0A5C_3E91);
    endfunction

    // One clock: drive at a falling edge, update the model, return at the next.
    task automatic cyc(input logic sh, input logic d, input logic ld, input logic md);
        shift_en = sh; ser_data = d; xfer_strobe = ld; sel_group = md;
        @(negedge clk);
        if (!setup_n) begin
            m_heat = '0; m_tok = 0; m_done = 1'b0;
        end else begin
            m_done = 1'b0;
            if (ld && !md) begin
                m_heat = '0;
                for (int r = 0; r < R; r++) m_heat[m_tok*R + r] = m_sr[r];
                m_done = (m_tok == G - 1);
                m_tok  = (m_tok + 1) % G;
            end else if (ld && md) begin
                if (m_sr[4:0] < 5'd16) m_tok = int'(m_sr[4:0]);
            end
        end
        if (sh) m_sr = {m_sr[R-2:0], d};
        shift_en = 1'b0; xfer_strobe = 1'b0; sel_group = 1'b0;
    endtask

    task automatic load_word(input logic [R-1:0] w);
        for (int b = R - 1; b >= 0; b--) cyc(1'b1, w[b], 1'b0, 1'b0);
    endtask

    task automatic check(input string req);
        n_cmp++;
        if (heat_en !== m_heat) begin
            n_bad++;
            $display("FAIL %s heat_en actual %h expected %h", req, heat_en, m_heat);
        end
        n_cmp++;
        if (scan_done !== m_done) begin
            n_bad++;
            $display("FAIL %s scan_done actual %b expected %b", req, scan_done, m_done);
        end
    endtask

    initial begin
        #(4ns * 150000);
        n_bad++;
        $display("FAIL watchdog actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; setup_n = 1'b1; ser_data = 1'b0; shift_en = 1'b0;
        xfer_strobe = 1'b0; sel_group = 1'b0;
        m_sr = '0; m_tok = 0; m_heat = '0; m_done = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R7: two full passes over every group.
        for (int pass = 0; pass < 2; pass++) begin
            for (int g = 0; g < G; g++) begin
                load_word(pat(g + pass * 7));
                check("R7 hold while shifting");
                cyc(1'b0, 1'b0, 1'b1, 1'b0);
                check(g == G - 1 ? "R5 wrap pulse" : "R3 R2 R4 row release");
                cyc(1'b0, 1'b0, 1'b0, 1'b0);
                check("R5 pulse is one cycle");
            end
        end

        // R6: place token on group 9, heat unchanged, then release there.
        load_word(R'(9));
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        check("R6 group transfer keeps heat");
        load_word(pat(40));
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R6 row lands on placed group");
        // R6: out-of-range number 20 is ignored, token stays on group 10.
        load_word(R'(20));
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        check("R6 out-of-range group ignored");
        load_word(pat(41));
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R6 token unmoved by bad number");

        // R9: shift and transfer together use the pre-shift word.
        load_word({R{1'b1}});
        cyc(1'b1, 1'b0, 1'b1, 1'b0);
        check("R9 simultaneous uses old word");
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R9 shifted word next");

        // R8: setup phase clears and ignores transfers.
        setup_n = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 setup clears heat");
        load_word(pat(50));
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R8 ring transfer ignored");
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        check("R8 group transfer ignored");
        setup_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R8 token back at group 0");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule